// File: doc/BRIEF.md
# NAND Host Bus-Cycle Sequencer

This block is the host-side engine behind one 8-bit multiplexed NAND flash bus. A client hands it a request made of an opcode byte, a 29-bit linear address, an address-cycle count (four or five), a direction and a byte count. The sequencer then produces the whole pin-level conversation. It sends a command cycle, then the address cycles with the linear address cut into the padded byte layout the flash expects. After that it either streams data bytes in from a write stream, or waits on the active-low ready/busy line and pulls data out with read-enable pulses onto a valid/ready read stream.

All strobe timing is counted in system-clock cycles. Write-enable and read-enable each have a low width and a high width set by parameters. The ready/busy input goes through a synchroniser. After the address phase of a read, the block waits a settle window and then waits for the line to go high. If the line stays low past a cycle limit, the operation is abandoned and the completion pulse carries an error flag. A request with a byte count of zero stops after the address cycles, which covers erase-style and setup-only operations.

Top module: `nand_seq_top`

## Requirements
- R1: While reset is asserted and on leaving it, chip enable, write enable and read enable are high, both latch enables and the data-bus drive are low, and `req_ready` is high.
- R2: A command cycle has chip enable low, command latch high, address latch low and read enable high. The opcode is on `nand_dq_o` and stays stable while write enable is low. Write enable goes low for exactly WE_LOW clock cycles and then rises, which is the capture edge.
- R3: Address cycles have address latch high and command latch low. There are 4 of them when `req_five` is 0 and 5 when it is 1.
- R4: The address bytes leave in this order: addr[7:0]; {4'b0, addr[11:8]}; addr[19:12]; addr[27:20]; and, for the fifth cycle only, {7'b0, addr[28]}.
- R5: In a write request (`req_write`=1) with `req_len`=N>0, exactly N data cycles follow the address. Each data cycle has both latch enables low, read enable high and one write-enable pulse, and carries the bytes accepted from the write stream in order.
- R6: In a read request, no read-enable pulse happens while `nand_rb_n` is low. Readout starts only after the line has been seen high.
- R7: In a read request with `req_len`=N, exactly N read-enable pulses occur with write enable high and both latch enables low. The byte on `nand_dq_i` in the last low cycle of each pulse is presented on `rd_data` and held with `rd_valid` until `rd_ready`. No further read-enable pulse starts before that byte is taken.
- R8: If `nand_rb_n` stays low for BUSY_LIMIT watched cycles, the request ends with `done_err`=1 and no read-enable pulse. A request that completes normally ends with `done_err`=0.
- R9: `done_valid` is a one-cycle pulse at the end of every request. `req_ready` is low from acceptance until after that pulse.
- R10: Command latch and address latch are never high together, and write enable and read enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_opcode | input | 8 | Command byte |
| req_addr | input | 29 | Linear flash address |
| req_five | input | 1 | 1: five address cycles, 0: four |
| req_write | input | 1 | 1: data-in phase, 0: wait then readout |
| req_len | input | LEN_W | Number of data bytes (0: none) |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte consumed |
| rd_data | output | 8 | Read byte |
| done_valid | output | 1 | One-cycle end-of-request pulse |
| done_err | output | 1 | Busy timeout flag, valid with done_valid |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus value driven by the host |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus value from the flash |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
A wrong address-cycle index or lane select shows up as a misplaced or wrongly padded byte captured at a write-enable rising edge, within a few strobe periods of acceptance. A stuck or skipped state shows up as extra or missing strobe pulses, or as a completion pulse that never arrives. A broken busy counter shows up either as a read-enable fall while ready/busy is still low or as a missing error flag once the limit has passed. Wrong read-side hold logic shows up as a second read-enable pulse while a byte is still held back by `rd_ready`, or as the wrong byte reaching `rd_data`.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned LIN_ADDR_W = 29;
   localparam int unsigned MAX_LANES  = 5;
   localparam int unsigned LANE_IDX_W = 3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_WDATA,
      ST_WAIT,
      ST_RDATA,
      ST_RHOLD,
      ST_DONE
   } seq_state_e;

endpackage

// File: rtl/nand_addr_split.sv
module nand_addr_split
   import nand_seq_pkg::*;
#(
   parameter int unsigned AW = LIN_ADDR_W
) (
   input  logic [AW-1:0]         addr,
   input  logic [LANE_IDX_W-1:0] lane_sel,
   output logic [BYTE_W-1:0]     lane_byte
);

   logic [BYTE_W-1:0] lanes [MAX_LANES];

   // Each lane takes a slice of the linear address, zero-extended to a byte.
   for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
      localparam int unsigned LO = (k == 0) ? 0  :
                                   (k == 1) ? 8  :
                                   (k == 2) ? 12 :
                                   (k == 3) ? 20 : 28;
      localparam int unsigned WD = (k == 1) ? 4 : (k == 4) ? 1 : 8;
      assign lanes[k] = BYTE_W'(addr[LO +: WD]);
   end

   always_comb begin
      lane_byte = '0;
      if (lane_sel < LANE_IDX_W'(MAX_LANES))
         lane_byte = lanes[lane_sel];
   end

endmodule

// File: rtl/nand_pulse.sv
module nand_pulse #(
   parameter int unsigned LOW_CYC  = 2,
   parameter int unsigned HIGH_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic strobe_n,
   output logic sample,
   output logic fin
);

   localparam int unsigned MAXC  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
   localparam int unsigned CNT_W = $clog2(MAXC + 1);

   logic             low_q;
   logic             high_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= 1'b0;
         high_q <= 1'b0;
         cnt_q  <= '0;
      end else if (low_q) begin
         if (cnt_q == '0) begin
            low_q  <= 1'b0;
            high_q <= 1'b1;
            cnt_q  <= CNT_W'(HIGH_CYC - 1);
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else if (high_q) begin
         if (cnt_q == '0)
            high_q <= 1'b0;
         else
            cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
         low_q <= 1'b1;
         cnt_q <= CNT_W'(LOW_CYC - 1);
      end
   end

   assign busy     = low_q | high_q;
   assign strobe_n = ~low_q;
   assign sample   = low_q & (cnt_q == '0);
   assign fin      = high_q & (cnt_q == '0);

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_n_async,
   output logic rb_hi
);

   if (STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b0;
         else        s_q <= rb_n_async;
      end
      assign rb_hi = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2:0], rb_n_async};
      end
      assign rb_hi = sh_q[STAGES-1];
   end

endmodule

// File: rtl/nand_wait_ctrl.sv
module nand_wait_ctrl #(
   parameter int unsigned SETTLE_CYC = 4,
   parameter int unsigned LIMIT_CYC  = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic rb_hi,
   output logic ok,
   output logic tmo
);

   localparam int unsigned MAXC = (SETTLE_CYC > LIMIT_CYC) ? SETTLE_CYC : LIMIT_CYC;
   localparam int unsigned CW   = $clog2(MAXC + 1);

   logic          active_q;
   logic          settle_q;
   logic [CW-1:0] cnt_q;
   logic          watching;

   assign watching = active_q & ~settle_q;
   assign ok       = watching & rb_hi;
   assign tmo      = watching & ~rb_hi & (cnt_q == CW'(LIMIT_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         settle_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!active_q) begin
         if (start) begin
            active_q <= 1'b1;
            settle_q <= 1'b1;
            cnt_q    <= '0;
         end
      end else if (settle_q) begin
         if (cnt_q == CW'(SETTLE_CYC - 1)) begin
            settle_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (ok || tmo) begin
         active_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
   import nand_seq_pkg::*;
#(
   parameter int unsigned WE_LOW      = 2,
   parameter int unsigned WE_HIGH     = 2,
   parameter int unsigned RE_LOW      = 2,
   parameter int unsigned RE_HIGH     = 2,
   parameter int unsigned SETTLE      = 4,
   parameter int unsigned BUSY_LIMIT  = 100000,
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [7:0]       req_opcode,
   input  logic [28:0]      req_addr,
   input  logic             req_five,
   input  logic             req_write,
   input  logic [LEN_W-1:0] req_len,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [7:0]       rd_data,
   output logic             done_valid,
   output logic             done_err,
   output logic             nand_ce_n,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [7:0]       nand_dq_o,
   output logic             nand_dq_oe,
   input  logic [7:0]       nand_dq_i,
   input  logic             nand_rb_n
);

   initial begin
      assert (WE_LOW >= 1 && WE_HIGH >= 1) else $error("write strobe widths must be at least one cycle");
      assert (RE_LOW >= 1 && RE_HIGH >= 1) else $error("read strobe widths must be at least one cycle");
      assert (SETTLE >= 1 && BUSY_LIMIT >= 1) else $error("wait windows must be at least one cycle");
      assert (SYNC_STAGES >= 1) else $error("synchroniser needs at least one stage");
      assert (LEN_W >= 1) else $error("length width must be positive");
   end

   localparam logic [LANE_IDX_W-1:0] LAST4 = LANE_IDX_W'(3);
   localparam logic [LANE_IDX_W-1:0] LAST5 = LANE_IDX_W'(4);

   seq_state_e               state_q;
   logic [BYTE_W-1:0]        op_q;
   logic [LIN_ADDR_W-1:0]    addr_q;
   logic                     five_q;
   logic                     write_q;
   logic [LEN_W-1:0]         len_q;
   logic [LANE_IDX_W-1:0]    lane_q;
   logic [LEN_W-1:0]         cnt_q;
   logic                     launched_q;
   logic [BYTE_W-1:0]        wbyte_q;
   logic [BYTE_W-1:0]        rbyte_q;
   logic                     err_q;

   logic we_start, we_busy, we_strobe_n, we_sample, we_fin;
   logic re_start, re_busy, re_strobe_n, re_sample, re_fin;
   logic rb_hi, wait_start, wait_ok, wait_tmo;
   logic [BYTE_W-1:0] lane_byte;
   logic lane_last, byte_last;

   assign lane_last = (lane_q == (five_q ? LAST5 : LAST4));
   assign byte_last = (cnt_q == len_q - LEN_W'(1));

   nand_addr_split #(.AW(LIN_ADDR_W)) split_i (
      .addr      (addr_q),
      .lane_sel  (lane_q),
      .lane_byte (lane_byte)
   );

   nand_pulse #(.LOW_CYC(WE_LOW), .HIGH_CYC(WE_HIGH)) we_gen_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (we_start),
      .busy     (we_busy),
      .strobe_n (we_strobe_n),
      .sample   (we_sample),
      .fin      (we_fin)
   );

   nand_pulse #(.LOW_CYC(RE_LOW), .HIGH_CYC(RE_HIGH)) re_gen_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (re_start),
      .busy     (re_busy),
      .strobe_n (re_strobe_n),
      .sample   (re_sample),
      .fin      (re_fin)
   );

   nand_rb_sync #(.STAGES(SYNC_STAGES)) rb_sync_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rb_n_async (nand_rb_n),
      .rb_hi      (rb_hi)
   );

   nand_wait_ctrl #(.SETTLE_CYC(SETTLE), .LIMIT_CYC(BUSY_LIMIT)) wait_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wait_start),
      .rb_hi (rb_hi),
      .ok    (wait_ok),
      .tmo   (wait_tmo)
   );

   // Strobe launch conditions
   assign wr_ready   = (state_q == ST_WDATA) & ~launched_q & ~we_busy;
   assign we_start   = ~launched_q & ~we_busy &
                       ((state_q == ST_CMD) | (state_q == ST_ADDR) |
                        ((state_q == ST_WDATA) & wr_valid));
   assign re_start   = (state_q == ST_RDATA) & ~launched_q & ~re_busy;
   assign wait_start = (state_q == ST_ADDR) & we_fin & lane_last &
                       ~write_q & (len_q != '0);
   // The sampling pulse of the write generator is not needed by this sequencer.
   logic unused_we_sample;
   assign unused_we_sample = we_sample;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_q       <= '0;
         addr_q     <= '0;
         five_q     <= 1'b0;
         write_q    <= 1'b0;
         len_q      <= '0;
         lane_q     <= '0;
         cnt_q      <= '0;
         launched_q <= 1'b0;
         wbyte_q    <= '0;
         rbyte_q    <= '0;
         err_q      <= 1'b0;
      end else begin
         if (we_fin || re_fin)
            launched_q <= 1'b0;
         else if (we_start || re_start)
            launched_q <= 1'b1;

         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q    <= req_opcode;
                  addr_q  <= req_addr;
                  five_q  <= req_five;
                  write_q <= req_write;
                  len_q   <= req_len;
                  err_q   <= 1'b0;
                  state_q <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (we_fin) begin
                  lane_q  <= '0;
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (we_fin) begin
                  if (!lane_last)
                     lane_q <= lane_q + 1'b1;
                  else if (len_q == '0)
                     state_q <= ST_DONE;
                  else begin
                     cnt_q   <= '0;
                     state_q <= write_q ? ST_WDATA : ST_WAIT;
                  end
               end
            end
            ST_WDATA: begin
               if (wr_valid && wr_ready)
                  wbyte_q <= wr_data;
               if (we_fin) begin
                  if (byte_last) state_q <= ST_DONE;
                  else           cnt_q   <= cnt_q + 1'b1;
               end
            end
            ST_WAIT: begin
               if (wait_ok) begin
                  cnt_q   <= '0;
                  state_q <= ST_RDATA;
               end else if (wait_tmo) begin
                  err_q   <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            ST_RDATA: begin
               if (re_sample)
                  rbyte_q <= nand_dq_i;
               if (re_fin)
                  state_q <= ST_RHOLD;
            end
            ST_RHOLD: begin
               if (rd_ready) begin
                  if (byte_last)
                     state_q <= ST_DONE;
                  else begin
                     cnt_q   <= cnt_q + 1'b1;
                     state_q <= ST_RDATA;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Pin and stream decode
   always_comb begin
      unique case (state_q)
         ST_CMD:  nand_dq_o = op_q;
         ST_ADDR: nand_dq_o = lane_byte;
         default: nand_dq_o = wbyte_q;
      endcase
   end

   assign nand_ce_n  = (state_q == ST_IDLE) | (state_q == ST_DONE);
   assign nand_cle   = (state_q == ST_CMD);
   assign nand_ale   = (state_q == ST_ADDR);
   assign nand_we_n  = we_strobe_n;
   assign nand_re_n  = re_strobe_n;
   assign nand_dq_oe = (state_q == ST_CMD) | (state_q == ST_ADDR) | (state_q == ST_WDATA);

   assign req_ready  = (state_q == ST_IDLE);
   assign rd_valid   = (state_q == ST_RHOLD);
   assign rd_data    = rbyte_q;
   assign done_valid = (state_q == ST_DONE);
   assign done_err   = err_q;

endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       rd_valid,
   input logic       rd_ready,
   input logic [7:0] rd_data,
   input logic       done_valid,
   input logic       nand_ce_n,
   input logic       nand_cle,
   input logic       nand_ale,
   input logic       nand_we_n,
   input logic       nand_re_n,
   input logic [7:0] nand_dq_o,
   input logic       nand_dq_oe
);

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (nand_we_n && nand_re_n && nand_ce_n && !nand_cle && !nand_ale && !nand_dq_oe));

   assert_we_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> (!nand_ce_n && nand_re_n));

   assert_dq_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o));

   assert_we_drives_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_we_n |-> nand_dq_oe);

   assert_re_latches_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> (!nand_cle && !nand_ale && nand_we_n && !nand_ce_n));

   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !req_ready);

   assert_latch_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

endmodule

bind nand_seq_top nand_seq_checker chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .rd_ready   (rd_ready),
   .rd_data    (rd_data),
   .done_valid (done_valid),
   .nand_ce_n  (nand_ce_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_dq_o  (nand_dq_o),
   .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_seq_top_tb.sv
module nand_seq_top_tb_top;

   localparam int WE_LOW  = 2;
   localparam int WE_HIGH = 1;
   localparam int RE_LOW  = 3;
   localparam int RE_HIGH = 1;
   localparam int SETTLE  = 2;
   localparam int LIMIT   = 40;
   localparam int LEN_W   = 8;
   localparam int SYNC    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [7:0]       req_opcode = '0;
   logic [28:0]      req_addr = '0;
   logic             req_five = 1'b0;
   logic             req_write = 1'b0;
   logic [LEN_W-1:0] req_len = '0;
   logic             wr_valid = 1'b0;
   logic             wr_ready;
   logic [7:0]       wr_data = '0;
   logic             rd_valid;
   logic             rd_ready = 1'b0;
   logic [7:0]       rd_data;
   logic             done_valid, done_err;
   logic             nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]       nand_dq_o;
   logic [7:0]       dq_model = '0;
   logic             rb_drv = 1'b1;

   nand_seq_top #(
      .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW), .RE_HIGH(RE_HIGH),
      .SETTLE(SETTLE), .BUSY_LIMIT(LIMIT), .LEN_W(LEN_W), .SYNC_STAGES(SYNC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
      .req_addr(req_addr), .req_five(req_five), .req_write(req_write), .req_len(req_len),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .done_valid(done_valid), .done_err(done_err),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(dq_model), .nand_rb_n(rb_drv)
   );

   int checks = 0;
   int errors = 0;

   // Flash-side observations
   logic [10:0] cap [0:63];     // {ce_n, cle, ale, dq}
   int ncap = 0;
   int we_run = 0;
   int we_bad = 0;
   int re_falls = 0;
   int re_busy_viol = 0;
   int re_bus_viol = 0;
   int re_ahead = 0;

   // Stream sides
   logic [7:0] wr_src [0:15];
   int wr_total = 0;
   int wr_idx = 0;
   logic wr_fire = 1'b0;
   logic [7:0] rd_got [0:15];
   int rd_acc = 0;
   logic rd_bp = 1'b0;
   int cyc = 0;

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_lane(input logic [28:0] a, input int k);
      case (k)
         0: return a[7:0];
         1: return {4'b0, a[11:8]};
         2: return a[19:12];
         3: return a[27:20];
         default: return {7'b0, a[28]};
      endcase
   endfunction

   function automatic logic [7:0] flash_byte(input int k);
      return 8'(8'h3C + 8'h11 * k);
   endfunction

   always @(posedge nand_we_n) begin
      if (rst_n === 1'b1 && ncap < 64) begin
         cap[ncap] = {nand_ce_n, nand_cle, nand_ale, nand_dq_o};
         ncap++;
      end
   end

   always @(negedge nand_re_n) begin
      if (rst_n === 1'b1) begin
         if (!rb_drv) re_busy_viol++;
         if (nand_cle || nand_ale || !nand_we_n || nand_ce_n) re_bus_viol++;
         if (re_falls > rd_acc) re_ahead++;
         dq_model = flash_byte(re_falls);
         re_falls++;
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!nand_we_n) we_run++;
         else begin
            if (we_run != 0 && we_run != WE_LOW) we_bad++;
            we_run = 0;
         end
      end
      if (wr_fire) wr_idx++;
      wr_valid = (wr_idx < wr_total);
      wr_data  = wr_src[wr_idx[3:0]];
      wr_fire  = wr_valid && wr_ready;
      rd_ready = !(rd_bp && (cyc % 3 == 0));
      if (rd_valid && rd_ready && rd_acc < 16) begin
         rd_got[rd_acc] = rd_data;
         rd_acc++;
      end
   end

   task automatic clear_mon();
      ncap = 0; we_bad = 0; re_falls = 0; re_busy_viol = 0; re_bus_viol = 0;
      re_ahead = 0; rd_acc = 0; wr_idx = 0; wr_total = 0; wr_fire = 1'b0;
   endtask

   task automatic send_req(input logic [7:0] op, input logic [28:0] a, input logic five,
                           input logic wr, input int len);
      @(negedge clk);
      req_valid = 1'b1; req_opcode = op; req_addr = a; req_five = five;
      req_write = wr; req_len = LEN_W'(len);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 req_ready low while active", int'(req_ready), 0);
   endtask

   task automatic wait_done(input string req, output logic err);
      int n = 0;
      err = 1'b0;
      while (!done_valid && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk({req, " done pulse seen"}, int'(done_valid), 1);
      err = done_err;
      @(negedge clk);
      chk("R9 done pulse one cycle", int'(done_valid), 0);
   endtask

   task automatic check_header(input logic [7:0] op, input logic [28:0] a, input int lanes);
      chk("R2 command cycle latches and opcode", int'(cap[0]), int'({1'b0, 1'b1, 1'b0, op}));
      for (int k = 0; k < lanes; k++)
         chk("R4 address byte layout R3 address latch", int'(cap[1 + k]),
             int'({1'b0, 1'b0, 1'b1, exp_lane(a, k)}));
   endtask

   task automatic t_reset();
      chk("R1 reset we_n", int'(nand_we_n), 1);
      chk("R1 reset re_n", int'(nand_re_n), 1);
      chk("R1 reset ce_n", int'(nand_ce_n), 1);
      chk("R1 reset latches and drive", int'({nand_cle, nand_ale, nand_dq_oe}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", int'(req_ready), 1);
   endtask

   task automatic t_cmd_addr4();
      logic err;
      clear_mon();
      send_req(8'h60, 29'h1ABCDEF3, 1'b0, 1'b0, 0);
      wait_done("R3", err);
      chk("R3 four address cycles plus command", ncap, 5);
      check_header(8'h60, 29'h1ABCDEF3, 4);
      chk("R2 write pulse width", we_bad, 0);
      chk("R8 no error on normal end", int'(err), 0);
   endtask

   task automatic t_addr5();
      logic err;
      clear_mon();
      send_req(8'hD5, 29'h10000A5F, 1'b1, 1'b0, 0);
      wait_done("R3", err);
      chk("R3 five address cycles plus command", ncap, 6);
      check_header(8'hD5, 29'h10000A5F, 5);
      chk("R2 write pulse width", we_bad, 0);
   endtask

   task automatic t_write();
      logic err;
      clear_mon();
      wr_src[0] = 8'hC3; wr_src[1] = 8'h00; wr_src[2] = 8'hFF;
      wr_total = 3;
      send_req(8'h80, 29'h0345_6789, 1'b0, 1'b1, 3);
      wait_done("R5", err);
      chk("R5 data cycles count", ncap, 8);
      check_header(8'h80, 29'h0345_6789, 4);
      for (int k = 0; k < 3; k++)
         chk("R5 data cycle latches and byte", int'(cap[5 + k]), int'({3'b000, wr_src[k]}));
      chk("R5 read enable stays high", re_falls, 0);
      chk("R5 all bytes taken", wr_idx, 3);
      chk("R2 write pulse width", we_bad, 0);
   endtask

   task automatic t_read();
      logic err;
      clear_mon();
      rd_bp = 1'b1;
      rb_drv = 1'b0;
      fork
         begin
            repeat (30) @(negedge clk);
            rb_drv = 1'b1;
         end
      join_none
      send_req(8'h00, 29'h1F00_0123, 1'b1, 1'b0, 4);
      wait_done("R7", err);
      chk("R6 no read strobe while busy", re_busy_viol, 0);
      chk("R7 read pulse count", re_falls, 4);
      chk("R7 bytes delivered", rd_acc, 4);
      for (int k = 0; k < 4; k++)
         chk("R7 read byte value", int'(rd_got[k]), int'(flash_byte(k)));
      chk("R7 latches low and write high during reads", re_bus_viol, 0);
      chk("R7 no strobe ahead of consumer", re_ahead, 0);
      chk("R7 only header write pulses", ncap, 6);
      chk("R8 no error after busy released", int'(err), 0);
      rd_bp = 1'b0;
   endtask

   task automatic t_timeout();
      logic err;
      clear_mon();
      rb_drv = 1'b0;
      send_req(8'h00, 29'h0000_0040, 1'b0, 1'b0, 2);
      wait_done("R8", err);
      chk("R8 timeout error flag", int'(err), 1);
      chk("R8 no read strobe after timeout", re_falls, 0);
      chk("R8 no data delivered", rd_acc, 0);
      rb_drv = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9 idle after timeout", int'(req_ready), 1);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_cmd_addr4();
      t_addr5();
      t_write();
      t_read();
      t_timeout();
      finish_run();
   end

endmodule